// File: doc/BRIEF.md
# Saturating MAC Event Counters With Clear-On-Read

This block keeps the small event statistics a MAC reports to its host. Four 4-bit counters share one 16-bit counter word, and a separate 8-bit counter tallies frames dropped because an external discard request was active. Each input is a single-cycle event pulse that the surrounding MAC logic produces.

None of the counters wraps. Each one stops at its all-ones value. When a 4-bit counter reaches 15, it sets a roll-over flag. When the drop counter reaches 255, it sets a drop flag. Each flag drives its own maskable interrupt output.

The host reads the block through a read strobe and a 2-bit select. A read returns the selected word one cycle later on a registered data port. As a side effect, the read clears the word it returned. An event that arrives in the same cycle as a clearing read is not lost: it becomes the first count of the new interval.

Top module: `mac_stat_counters`

## Requirements
- R1: Counter i, for i from 0 to 3, sits in bits [4i+3:4i] of the counter word. It adds one in every cycle in which `evt_pulse[i]` is high.
- R2: A 4-bit counter that holds 15 stays at 15 when further events arrive.
- R3: A read with `rd_sel` = 0 returns the counter word as it was before that clock edge, and clears all four counters. A counter that gets an event in the same cycle as this read becomes 1.
- R4: The roll-over flag sets in the cycle in which any 4-bit counter goes from 14 to 15. It appears in bit 0 of the status word. A read with `rd_sel` = 1 returns the status word and clears the flag.
- R5: `sat_irq` is high exactly one cycle after the roll-over flag was high while `sat_irq_en` was high. With `sat_irq_en` low, `sat_irq` stays low, but the flag still sets.
- R6: The 8-bit drop counter adds one per cycle with `drop_pulse` high. A read with `rd_sel` = 2 returns it in bits [7:0], with the upper bits zero, and clears it. A drop in the same cycle as that read leaves the counter at 1.
- R7: The drop counter holds at 255 and does not wrap.
- R8: The drop flag sets when the drop counter goes from 254 to 255. It appears in bit 1 of the status word and is cleared by a read with `rd_sel` = 2. `drop_irq` is high one cycle after the flag was high while `drop_irq_en` was high.
- R9: `rd_data` changes only at a clock edge that has `rd_stb` high, and holds its value otherwise. A read with `rd_sel` = 3 returns zero and clears nothing.
- R10: After reset, all counters, flags, interrupts and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | One event pulse per 4-bit counter |
| drop_pulse | input | 1 | Pulse for each frame dropped on the external discard request |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| rd_sel | input | 2 | Read select: 0 counter word, 1 status, 2 drop counter, 3 none |
| sat_irq_en | input | 1 | Mask for the roll-over interrupt |
| drop_irq_en | input | 1 | Mask for the drop interrupt |
| rd_data | output | 16 | Registered read data |
| roll_status | output | 1 | Roll-over flag |
| sat_irq | output | 1 | Roll-over interrupt |
| drop_irq | output | 1 | Drop-counter interrupt |

## Verification
Directed patterns come first. Single-lane bursts of different lengths show that each field counts only its own input. Long all-lane bursts push every field past 15 to show that it holds rather than wraps. A read issued together with an event separates "clear then count" from "count then clear" or "clear wins". Three hundred drop pulses show the 8-bit counter holding at 255, and reads on select 3 show that an idle select neither returns data nor clears.

A long random run follows. It uses dense events, sparse reads on all selects and toggled masks, so that flag setting, flag clearing and mask gating interleave in orders the directed cases do not reach.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DROP = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_t;

  localparam int STAT_ROLL_BIT = 0;
  localparam int STAT_DROP_BIT = 1;

endpackage

// File: rtl/stat_sat_cnt.sv
module stat_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         hit_max
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic at_max;

  assign at_max  = (cnt == MAXV);
  // Pulses in the cycle whose edge moves the count onto the ceiling.
  assign hit_max = inc & ~clr & (cnt == (MAXV - ONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= inc ? ONE : '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/stat_sticky.sv
module stat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic q,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      irq <= 1'b0;
    end else begin
      // set wins against a clearing read in the same cycle
      q   <= set | (q & ~clr);
      irq <= q & irq_en;
    end
  end

endmodule

// File: rtl/mac_stat_counters.sv
module mac_stat_counters
  import mac_stat_pkg::*;
#(
  parameter int N_EVT  = 4,
  parameter int EVT_W  = 4,
  parameter int DROP_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic              drop_pulse,
  input  logic              rd_stb,
  input  logic [1:0]        rd_sel,
  input  logic              sat_irq_en,
  input  logic              drop_irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              roll_status,
  output logic              sat_irq,
  output logic              drop_irq
);

  localparam int WORD_W = N_EVT * EVT_W;

  logic [WORD_W-1:0] evt_word;
  logic [N_EVT-1:0]  evt_hit;
  logic [DROP_W-1:0] drop_cnt;
  logic              drop_hit;
  logic              roll_flag;
  logic              drop_flag;
  rd_sel_t           sel;
  logic              clr_evt;
  logic              clr_stat;
  logic              clr_drop;
  logic [DATA_W-1:0] rd_next;

  assign sel      = rd_sel_t'(rd_sel);
  assign clr_evt  = rd_stb && (sel == SEL_EVT);
  assign clr_stat = rd_stb && (sel == SEL_STAT);
  assign clr_drop = rd_stb && (sel == SEL_DROP);

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    stat_sat_cnt #(.W(EVT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc     (evt_pulse[g]),
      .clr     (clr_evt),
      .cnt     (evt_word[g*EVT_W +: EVT_W]),
      .hit_max (evt_hit[g])
    );
  end

  stat_sat_cnt #(.W(DROP_W)) u_drop (
    .clk     (clk),
    .rst     (rst),
    .inc     (drop_pulse),
    .clr     (clr_drop),
    .cnt     (drop_cnt),
    .hit_max (drop_hit)
  );

  stat_sticky u_roll (
    .clk    (clk),
    .rst    (rst),
    .set    (|evt_hit),
    .clr    (clr_stat),
    .irq_en (sat_irq_en),
    .q      (roll_flag),
    .irq    (sat_irq)
  );

  stat_sticky u_dropf (
    .clk    (clk),
    .rst    (rst),
    .set    (drop_hit),
    .clr    (clr_drop),
    .irq_en (drop_irq_en),
    .q      (drop_flag),
    .irq    (drop_irq)
  );

  assign roll_status = roll_flag;

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_EVT:  rd_next[WORD_W-1:0] = evt_word;
      SEL_STAT: begin
        rd_next[STAT_ROLL_BIT] = roll_flag;
        rd_next[STAT_DROP_BIT] = drop_flag;
      end
      SEL_DROP: rd_next[DROP_W-1:0] = drop_cnt;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/stat_counters_chk.sv
module stat_counters_chk #(
  parameter int N_EVT  = 4,
  parameter int EVT_W  = 4,
  parameter int DROP_W = 8,
  parameter int DATA_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_stb,
  input logic [1:0]              rd_sel,
  input logic                    sat_irq_en,
  input logic                    drop_irq_en,
  input logic [N_EVT*EVT_W-1:0]  evt_word,
  input logic [DROP_W-1:0]       drop_cnt,
  input logic                    roll_flag,
  input logic                    drop_flag,
  input logic                    sat_irq,
  input logic                    drop_irq,
  input logic [DATA_W-1:0]       rd_data
);

  localparam logic [EVT_W-1:0]  EMAX = '1;
  localparam logic [DROP_W-1:0] DMAX = '1;

  logic past_ok;
  logic rd_evt;
  logic rd_drop;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign rd_evt  = rd_stb && (rd_sel == 2'd0);
  assign rd_drop = rd_stb && (rd_sel == 2'd2);

  for (genvar g = 0; g < N_EVT; g++) begin : g_chk
    // R2
    evt_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      ($past(evt_word[g*EVT_W +: EVT_W]) == EMAX && !$past(rd_evt))
      |-> (evt_word[g*EVT_W +: EVT_W] == EMAX));
    // R3
    evt_clr_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      $past(rd_evt) |-> (evt_word[g*EVT_W +: EVT_W] <= EVT_W'(1)));
    // R4
    roll_set_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
      ((evt_word[g*EVT_W +: EVT_W] == EMAX) && ($past(evt_word[g*EVT_W +: EVT_W]) != EMAX))
      |-> roll_flag);
  end

  // R5
  sat_irq_src_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    sat_irq |-> $past(roll_flag && sat_irq_en));

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(drop_cnt) == DMAX && !$past(rd_drop)) |-> (drop_cnt == DMAX));

  // R8
  drop_irq_src_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    drop_irq |-> $past(drop_flag && drop_irq_en));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(rd_stb) |-> $stable(rd_data));

endmodule

bind mac_stat_counters stat_counters_chk #(
  .N_EVT  (N_EVT),
  .EVT_W  (EVT_W),
  .DROP_W (DROP_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rd_stb      (rd_stb),
  .rd_sel      (rd_sel),
  .sat_irq_en  (sat_irq_en),
  .drop_irq_en (drop_irq_en),
  .evt_word    (evt_word),
  .drop_cnt    (drop_cnt),
  .roll_flag   (roll_flag),
  .drop_flag   (drop_flag),
  .sat_irq     (sat_irq),
  .drop_irq    (drop_irq),
  .rd_data     (rd_data)
);

// File: tb/mac_stat_counters_tb_top.sv
`timescale 1ns/1ps
module mac_stat_counters_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  evt_pulse;
  logic        drop_pulse;
  logic        rd_stb;
  logic [1:0]  rd_sel;
  logic        sat_irq_en;
  logic        drop_irq_en;
  logic [15:0] rd_data;
  logic        roll_status;
  logic        sat_irq;
  logic        drop_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int          m_cnt [4];
  int          m_drop;
  bit          m_rf, m_df, m_si, m_di;
  logic [15:0] m_rd;

  always #2 clk = ~clk;

  mac_stat_counters dut_i (
    .clk         (clk),
    .rst         (rst),
    .evt_pulse   (evt_pulse),
    .drop_pulse  (drop_pulse),
    .rd_stb      (rd_stb),
    .rd_sel      (rd_sel),
    .sat_irq_en  (sat_irq_en),
    .drop_irq_en (drop_irq_en),
    .rd_data     (rd_data),
    .roll_status (roll_status),
    .sat_irq     (sat_irq),
    .drop_irq    (drop_irq)
  );

  function automatic int nxt(int c, bit inc, bit clr, int maxv);
    if (clr) return inc ? 1 : 0;
    if (inc && c < maxv) return c + 1;
    return c;
  endfunction

  function automatic logic [15:0] word_of();
    return {m_cnt[3][3:0], m_cnt[2][3:0], m_cnt[1][3:0], m_cnt[0][3:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One cycle: inputs are driven at the falling edge, the model steps at
  // the rising edge, and the outputs are compared at the next falling edge.
  task automatic cyc(logic [3:0] ev, bit drop, bit rd, logic [1:0] sel);
    bit   clr_e, clr_s, clr_d, hit_e, hit_d;
    string tag;
    evt_pulse  = ev;
    drop_pulse = drop;
    rd_stb     = rd;
    rd_sel     = sel;
    @(posedge clk);
    clr_e = rd && sel == 2'd0;
    clr_s = rd && sel == 2'd1;
    clr_d = rd && sel == 2'd2;
    if (rd) begin
      case (sel)
        2'd0: m_rd = word_of();
        2'd1: m_rd = {14'd0, m_df, m_rf};
        2'd2: m_rd = {8'd0, m_drop[7:0]};
        default: m_rd = 16'd0;
      endcase
    end
    m_si = m_rf & sat_irq_en;
    m_di = m_df & drop_irq_en;
    hit_e = 0;
    for (int i = 0; i < 4; i++) begin
      if (ev[i] && !clr_e && m_cnt[i] == 14) hit_e = 1;
      m_cnt[i] = nxt(m_cnt[i], ev[i], clr_e, 15);
    end
    hit_d  = drop && !clr_d && m_drop == 254;
    m_drop = nxt(m_drop, drop, clr_d, 255);
    m_rf   = hit_e | (m_rf & !clr_s);
    m_df   = hit_d | (m_df & !clr_d);
    @(negedge clk);
    if (!rd)            tag = "R9";
    else if (sel == 0)  tag = "R3";
    else if (sel == 1)  tag = "R4";
    else if (sel == 2)  tag = "R6";
    else                tag = "R9";
    chk(tag, rd_data, m_rd);
    chk("R4", roll_status, m_rf);
    chk("R5", sat_irq, m_si);
    chk("R8", drop_irq, m_di);
    evt_pulse  = '0;
    drop_pulse = 1'b0;
    rd_stb     = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; evt_pulse = '0; drop_pulse = 0; rd_stb = 0; rd_sel = 0;
    sat_irq_en = 1; drop_irq_en = 1;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    m_drop = 0; m_rf = 0; m_df = 0; m_si = 0; m_di = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", {rd_data, roll_status, sat_irq, drop_irq}, 19'd0);
    cyc(4'h0, 0, 1, 2'd0); chk("R10", rd_data, 16'h0000);
    cyc(4'h0, 0, 1, 2'd1); chk("R10", rd_data, 16'h0000);

    // R1 lane placement
    cyc(4'h1, 0, 0, 0);
    repeat (2) cyc(4'h2, 0, 0, 0);
    repeat (3) cyc(4'h4, 0, 0, 0);
    repeat (4) cyc(4'h8, 0, 0, 0);
    cyc(4'h0, 0, 1, 2'd0); chk("R1", rd_data, 16'h4321);

    // R2 ceiling, R4 flag, R5 interrupt
    repeat (20) cyc(4'hF, 0, 0, 0);
    chk("R5", sat_irq, 1'b1);
    cyc(4'h0, 0, 1, 2'd0); chk("R2", rd_data, 16'hFFFF);
    cyc(4'h0, 0, 1, 2'd1); chk("R4", rd_data[0], 1'b1);
    cyc(4'h0, 0, 1, 2'd1); chk("R4", rd_data[0], 1'b0);

    // R3 event together with a clearing read
    repeat (3) cyc(4'h5, 0, 0, 0);
    cyc(4'h5, 0, 1, 2'd0); chk("R3", rd_data, 16'h0303);
    cyc(4'h0, 0, 1, 2'd0); chk("R3", rd_data, 16'h0101);

    // R5 mask blocks the interrupt but not the flag
    sat_irq_en = 0;
    repeat (16) cyc(4'h1, 0, 0, 0);
    cyc(4'h0, 0, 0, 0); chk("R5", sat_irq, 1'b0);
    chk("R5", roll_status, 1'b1);
    cyc(4'h0, 0, 1, 2'd1);
    sat_irq_en = 1;
    cyc(4'h0, 0, 1, 2'd0);

    // R9 idle select returns zero and clears nothing
    repeat (2) cyc(4'h2, 0, 0, 0);
    cyc(4'h0, 0, 1, 2'd3); chk("R9", rd_data, 16'h0000);
    cyc(4'h0, 0, 1, 2'd0); chk("R9", rd_data, 16'h0020);

    // R6 drop counting with a same-cycle read, R7 ceiling, R8 flag
    repeat (5) cyc(4'h0, 1, 0, 0);
    cyc(4'h0, 1, 1, 2'd2); chk("R6", rd_data, 16'h0005);
    cyc(4'h0, 0, 1, 2'd2); chk("R6", rd_data, 16'h0001);
    repeat (300) cyc(4'h0, 1, 0, 0);
    chk("R8", drop_irq, 1'b1);
    cyc(4'h0, 0, 1, 2'd1); chk("R8", rd_data[1], 1'b1);
    cyc(4'h0, 0, 1, 2'd2); chk("R7", rd_data, 16'h00FF);
    cyc(4'h0, 0, 0, 0);    chk("R8", drop_irq, 1'b0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ev;
      bit dr, rd;
      logic [1:0] sl;
      ev = 4'($urandom);
      dr = ($urandom % 3) != 0;
      rd = ($urandom % 24) == 0;
      sl = 2'($urandom);
      if (($urandom % 200) == 0) sat_irq_en  = ~sat_irq_en;
      if (($urandom % 200) == 0) drop_irq_en = ~drop_irq_en;
      cyc(ev, dr, rd, sl);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule